// File: doc/BRIEF.md
# Latched Status Register with Masked Clear

This block holds a byte of sticky status flags for a host. Each flag is driven by an event or alarm line from elsewhere in the chip. These lines may be asynchronous to the register clock, so every line passes through a two-flop synchronizer first. Depending on a per-bit parameter, a flag then sets either while its synchronized input is high (level capture) or on its rising edge (edge capture). A small two-state machine per bit decides whether the flag is set or clear.

The host does not clear flags by plain reads. A host write acts as a selection mask. For every bit written as one, the readable copy takes the flag's current latched value and the flag clears. Bits written as zero keep their readable copy and their flag untouched. The intended sequence is mask write, read, then write back the read value ANDed with the mask. The write-back clears any flag whose event came in between. This lets software poll single bits without disturbing the others.

A separate mask register selects which flags can pull the active-low interrupt output low.

Top module: `evt_status_reg`

## Requirements
- R1: After reset the readable copy is all zeros (rd_data = 0x00 with rd_en = 1), every flag is clear, the interrupt mask is all zeros and irq_n is 1.
- R2: An input held high before clock edge k is latched at edge k+2 (two synchronizer stages). The flag stays set after the input drops, until the host clears it.
- R3: On a write, each bit with wr_data = 1 loads the readable copy with that flag's value from just before the edge, and the flag clears.
- R4: On a write, each bit with wr_data = 0 keeps its readable copy and leaves its flag unchanged.
- R5: rd_data shows the readable copy while rd_en = 1 and is 0x00 while rd_en = 0. Reads change no state.
- R6: A level-capture bit (LEVEL_MASK bit = 1, bits 0..3 in the bench) sets again right after a clear while its synchronized input is still high.
- R7: An edge-capture bit (LEVEL_MASK bit = 0, bits 4..7 in the bench) sets only on a 0-to-1 transition of its synchronized input. An input held high after a clear does not set it again.
- R8: If a flag's set condition occurs in the same cycle as its clear, the flag stays set. The readable copy still receives the flag's previous value.
- R9: irq_n is 0 exactly while some flag is set with its mask bit at 1.
- R10: A mask write (mask_we = 1) loads all of mask_data. The new mask governs irq_n from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | WIDTH | Event and alarm lines, asynchronous |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | WIDTH | Refresh/clear selection mask |
| rd_en | input | 1 | Status read strobe |
| rd_data | output | WIDTH | Readable copy of the status |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | WIDTH | New interrupt mask value |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with WIDTH = 8 and LEVEL_MASK = 0x0F. With these values both generate variants of the per-bit capture machine exist side by side. Level-capture re-setting can then be checked next to edge-capture non-re-setting, with the same write sequence. The width lets single-bit selection be checked against untouched neighbours. It also lets one flag be hidden by the mask while it is set.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;

    // State of one sticky status flag
    typedef enum logic {
        BIT_CLEAR = 1'b0,
        BIT_SET   = 1'b1
    } bit_state_e;

endpackage

// File: rtl/evt_sync2.sv
module evt_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/evt_bit_capture.sv
module evt_bit_capture
    import evt_status_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic clr_i,
    output logic set_now_o,
    output logic latched_o
);

    bit_state_e state_q;
    bit_state_e state_d;
    logic       set_now;

    generate
        if (IS_LEVEL) begin : g_level
            // Level capture: set condition while the input is high
            assign set_now = sync_i;
        end else begin : g_edge
            logic prev_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= sync_i;
            end
            // Edge capture: set condition only on a rising transition
            assign set_now = sync_i & ~prev_q;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BIT_CLEAR;
        else        state_q <= state_d;
    end

    // Transitions: CLEAR->SET on set condition; SET->CLEAR on clear without set
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BIT_CLEAR: state_d = set_now ? BIT_SET : BIT_CLEAR;
            BIT_SET:   state_d = (clr_i && !set_now) ? BIT_CLEAR : BIT_SET;
            default:   state_d = BIT_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        latched_o = (state_q == BIT_SET);
        set_now_o = set_now;
    end

endmodule

// File: rtl/evt_view_reg.sv
module evt_view_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lat_i,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_data,
    output logic [WIDTH-1:0] view_o,
    output logic [WIDTH-1:0] mask_o
);

    logic [WIDTH-1:0] view_q;
    logic [WIDTH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            view_q <= '0;
        end else if (wr_en) begin
            // selected bits snapshot the latched flags, others hold
            view_q <= (view_q & ~wr_data) | (lat_i & wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_data;
    end

    assign view_o = view_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] LEVEL_MASK = 8'h0F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt_i,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic             mask_we,
    input  logic [WIDTH-1:0] mask_data,
    output logic             irq_n
);

    logic [WIDTH-1:0] evt_sync;
    logic [WIDTH-1:0] clr_sel;
    logic [WIDTH-1:0] set_now;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] view_q;
    logic [WIDTH-1:0] mask_q;

    evt_sync2 #(.WIDTH(WIDTH)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(evt_i),
        .sync_o (evt_sync)
    );

    assign clr_sel = {WIDTH{wr_en}} & wr_data;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            evt_bit_capture #(.IS_LEVEL(LEVEL_MASK[b])) cap_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .sync_i   (evt_sync[b]),
                .clr_i    (clr_sel[b]),
                .set_now_o(set_now[b]),
                .latched_o(lat_q[b])
            );
        end
    endgenerate

    evt_view_reg #(.WIDTH(WIDTH)) view_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat_i    (lat_q),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .mask_we  (mask_we),
        .mask_data(mask_data),
        .view_o   (view_q),
        .mask_o   (mask_q)
    );

    assign rd_data = rd_en ? view_q : '0;
    assign irq_n   = ~|(lat_q & mask_q);

endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [WIDTH-1:0] wr_data,
    input logic             mask_we,
    input logic [WIDTH-1:0] mask_data,
    input logic [WIDTH-1:0] lat,
    input logic [WIDTH-1:0] set_now,
    input logic [WIDTH-1:0] view,
    input logic [WIDTH-1:0] mask,
    input logic             irq_n
);

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (($past(lat) & ~lat) == '0)); // R2

    AST_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((view ^ $past(lat)) & $past(wr_data)) == '0)); // R3

    AST_CLEAR_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((lat & $past(wr_data) & ~$past(set_now)) == '0)); // R3

    AST_UNSELECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((view ^ $past(view)) & ~$past(wr_data)) == '0)); // R4

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(view)); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_now != '0) |=> ((lat & $past(set_now)) == $past(set_now))); // R8

    AST_IRQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat & mask) != '0) |-> !irq_n); // R9

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_data))); // R10

endmodule

bind evt_status_reg evt_status_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .mask_we  (mask_we),
    .mask_data(mask_data),
    .lat      (lat_q),
    .set_now  (set_now),
    .view     (view_q),
    .mask     (mask_q),
    .irq_n    (irq_n)
);

// File: tb/evt_status_reg_tb.sv
`timescale 1ns/1ps
module evt_status_reg_tb_top;

    localparam int W = 8;
    localparam int NVEC = 34;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] evt_i = '0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] rd_data;
    logic         mask_we = 1'b0;
    logic [W-1:0] mask_data = '0;
    logic         irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evt_status_reg #(.WIDTH(W), .LEVEL_MASK(8'h0F)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .mask_we(mask_we), .mask_data(mask_data),
        .irq_n(irq_n)
    );

    // {evt, wr_en, wr_data, mask_we, mask_data, rd_en, exp_rd, exp_irq_n}
    localparam logic [35:0] VEC [NVEC] = '{
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 0  R1
        {8'h01,1'b0,8'h00,1'b1,8'hFF,1'b1,8'h00,1'b1}, // 1  R2 pulse on level bit 0
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 2  R2
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b0}, // 3  R2 latched at k+2
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b0}, // 4  R2 sticky
        {8'h00,1'b1,8'h01,1'b0,8'h00,1'b1,8'h01,1'b1}, // 5  R3 snapshot and clear
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b0,8'h00,1'b1}, // 6  R5 rd_en low
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h01,1'b1}, // 7  R5 read again
        {8'h00,1'b1,8'h01,1'b0,8'h00,1'b1,8'h00,1'b1}, // 8  R3 write-back
        {8'h10,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 9  R4
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 10 R4
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b0}, // 11 R4 bit4 set
        {8'h00,1'b1,8'h01,1'b0,8'h00,1'b1,8'h00,1'b0}, // 12 R4 bit4 untouched
        {8'h00,1'b1,8'h10,1'b0,8'h00,1'b1,8'h10,1'b1}, // 13 R3
        {8'h10,1'b0,8'h00,1'b1,8'hEF,1'b1,8'h10,1'b1}, // 14 R10 mask bit4 off
        {8'h10,1'b0,8'h00,1'b0,8'h00,1'b1,8'h10,1'b1}, // 15 R10
        {8'h10,1'b0,8'h00,1'b0,8'h00,1'b1,8'h10,1'b1}, // 16 R10 set but masked
        {8'h10,1'b0,8'h00,1'b1,8'hFF,1'b1,8'h10,1'b0}, // 17 R9 unmasked
        {8'h10,1'b1,8'h10,1'b0,8'h00,1'b1,8'h10,1'b1}, // 18 R7 clear, input high
        {8'h10,1'b0,8'h00,1'b0,8'h00,1'b1,8'h10,1'b1}, // 19 R7 no re-set
        {8'h00,1'b1,8'h10,1'b0,8'h00,1'b1,8'h00,1'b1}, // 20 R7
        {8'h02,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 21 R6
        {8'h02,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 22 R6
        {8'h02,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b0}, // 23 R6 latched
        {8'h02,1'b1,8'h02,1'b0,8'h00,1'b1,8'h02,1'b0}, // 24 R6 re-set
        {8'h00,1'b1,8'h02,1'b0,8'h00,1'b1,8'h02,1'b0}, // 25 R6 still high in sync
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h02,1'b0}, // 26 R6
        {8'h00,1'b1,8'h02,1'b0,8'h00,1'b1,8'h02,1'b1}, // 27 R6 finally clears
        {8'h00,1'b1,8'h02,1'b0,8'h00,1'b1,8'h00,1'b1}, // 28 R3
        {8'h20,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 29 R8
        {8'h00,1'b0,8'h00,1'b0,8'h00,1'b1,8'h00,1'b1}, // 30 R8
        {8'h00,1'b1,8'h20,1'b0,8'h00,1'b1,8'h00,1'b0}, // 31 R8 set beats clear
        {8'h00,1'b1,8'h20,1'b0,8'h00,1'b1,8'h20,1'b1}, // 32 R8
        {8'h00,1'b1,8'h20,1'b0,8'h00,1'b1,8'h00,1'b1}  // 33 R3
    };

    function automatic string req_of(int i);
        case (i)
            0:                      return "R1";
            1, 2, 3, 4:             return "R2";
            5, 8, 13, 28, 33:       return "R3";
            9, 10, 11, 12:          return "R4";
            6, 7:                   return "R5";
            21, 22, 23, 24, 25, 26, 27: return "R6";
            18, 19, 20:             return "R7";
            29, 30, 31, 32:         return "R8";
            17:                     return "R9";
            default:                return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [W-1:0] exp_rd, logic exp_irq);
        n_chk++;
        if (rd_data !== exp_rd || irq_n !== exp_irq) begin
            n_bad++;
            $display("FAIL %s: rd_data=%02h irq_n=%b expected rd_data=%02h irq_n=%b",
                     req, rd_data, irq_n, exp_rd, exp_irq);
        end
    endtask

    task automatic step(logic [W-1:0] e, logic w, logic [W-1:0] wd,
                        logic mw, logic [W-1:0] md, logic r);
        @(negedge clk);
        evt_i = e; wr_en = w; wr_data = wd; mask_we = mw; mask_data = md; rd_en = r;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            logic [35:0] v;
            v = VEC[i];
            step(v[35:28], v[27], v[26:19], v[18], v[17:10], v[9]);
            check(req_of(i), v[8:1], v[0]);
        end

        // Directed: reset clears a set flag and the mask (R1)
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        check("R9", 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 8'h00, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", 8'h00, 1'b1);
        // level input still high: flag sets again, but mask is zero after reset (R1, R10)
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        step(8'h04, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1);
        check("R1", 8'h00, 1'b1);
        step(8'h00, 1'b1, 8'h04, 1'b0, 8'h00, 1'b1);
        check("R6", 8'h04, 1'b1);
        // mask write takes effect: bit 2 still set (sync stage still high)
        step(8'h00, 1'b0, 8'h00, 1'b1, 8'h04, 1'b1);
        check("R10", 8'h04, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule